// File: doc/BRIEF.md
# Bit-Sliced Logic and Shift Unit

This block is a purely combinational 4-bit logic and shift unit assembled from one repeated 1-bit cell. Every cell receives its own bit of each operand, the operand-A bits held by the cells directly above and below it, and a shared 3-bit function select. The cell then produces one bit of the result. Chaining the cells gives a word-wide unit without any whole-word operator in the datapath.

Six functions are available: bitwise AND and OR of the two operands, complement of A, a straight copy of A, and one-place logical shifts of A in either direction with zero fill. A separate output carries the bit that a shift pushes off the end of the word. The block holds no state and has no clock. Results follow the inputs combinationally, so a surrounding pipeline can register them wherever its timing allows. No valid/ready handshake is present, because the unit never stalls and never buffers.

Top module: `bitslice_lsu`

## Requirements
- R1: With select 3'b000, f_o equals a_i bitwise-AND b_i.
- R2: With select 3'b001, f_o equals a_i bitwise-OR b_i.
- R3: With select 3'b010, f_o equals the bitwise complement of a_i, and b_i has no effect.
- R4: With select 3'b011, f_o equals a_i unchanged, and b_i has no effect.
- R5: With select 3'b100, bit i of f_o equals a_i[i-1] for i from 1 to 3, and bit 0 of f_o is 0 (logical shift left).
- R6: With select 3'b101, bit i of f_o equals a_i[i+1] for i from 0 to 2, and bit 3 of f_o is 0 (logical shift right).
- R7: Select values 3'b110 and 3'b111 drive f_o and spill_o to 0 for every operand value.
- R8: spill_o equals a_i[3] under select 3'b100, equals a_i[0] under select 3'b101, and is 0 under every other select value.
- R9: The result is combinational: f_o and spill_o reflect inputs applied in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A; the only source for complement, copy and shifts |
| b_i | input | 4 | Operand B; used only by AND and OR |
| op_i | input | 3 | Function select, encoded as listed in R1 to R7 |
| f_o | output | 4 | Result word |
| spill_o | output | 1 | Bit shifted out of the word by a shift; 0 otherwise |

## Verification
The bound checker evaluates the result for every select value and every input change. It checks the AND, OR, complement, copy and both shift results against whole-word expressions, and it checks that the spill bit and the unused codes behave as stated. The same-cycle response of R9, and the claim that b_i has no effect on the single-operand functions, appear only in the bench. The bench sweeps all 2048 combinations of select and operands, and it samples each one in the same cycle in which it is applied, against an integer reference model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_INV  = 3'b010,
    FN_COPY = 3'b011,
    FN_SHL  = 3'b100,
    FN_SHR  = 3'b101,
    FN_RSV6 = 3'b110,
    FN_RSV7 = 3'b111
  } lsu_fn_e;

endpackage

// File: rtl/lsu_cell.sv
// One bit of the unit: selects among own-bit logic and neighbour bits.
module lsu_cell
  import lsu_pkg::*;
(
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    a_from_lo,   // operand-A bit of the next lower cell (or 0 at the end)
  input  logic    a_from_hi,   // operand-A bit of the next higher cell (or 0 at the end)
  input  lsu_fn_e fn,
  output logic    f_bit
);

  always_comb begin
    unique case (fn)
      FN_AND:  f_bit = a_bit & b_bit;
      FN_OR:   f_bit = a_bit | b_bit;
      FN_INV:  f_bit = ~a_bit;
      FN_COPY: f_bit = a_bit;
      FN_SHL:  f_bit = a_from_lo;
      FN_SHR:  f_bit = a_from_hi;
      default: f_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_spill.sv
// Picks the bit leaving the word during a shift.
module lsu_spill
  import lsu_pkg::*;
(
  input  logic    top_bit,
  input  logic    bottom_bit,
  input  lsu_fn_e fn,
  output logic    spill
);

  always_comb begin
    unique case (fn)
      FN_SHL:  spill = top_bit;
      FN_SHR:  spill = bottom_bit;
      default: spill = 1'b0;
    endcase
  end

endmodule

// File: rtl/bitslice_lsu.sv
module bitslice_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] op_i,
  output logic [WIDTH-1:0] f_o,
  output logic             spill_o
);

  localparam int unsigned MSB = WIDTH - 1;

  lsu_fn_e fn;
  assign fn = lsu_fn_e'(op_i);

  // Neighbour links; the word ends feed a zero serial-in.
  logic [WIDTH-1:0] lo_link;
  logic [WIDTH-1:0] hi_link;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lo_end
      assign lo_link[i] = 1'b0;
    end else begin : g_lo_mid
      assign lo_link[i] = a_i[i-1];
    end

    if (i == MSB) begin : g_hi_end
      assign hi_link[i] = 1'b0;
    end else begin : g_hi_mid
      assign hi_link[i] = a_i[i+1];
    end

    lsu_cell u_cell (
      .a_bit     (a_i[i]),
      .b_bit     (b_i[i]),
      .a_from_lo (lo_link[i]),
      .a_from_hi (hi_link[i]),
      .fn        (fn),
      .f_bit     (f_o[i])
    );
  end

  lsu_spill u_spill (
    .top_bit    (a_i[MSB]),
    .bottom_bit (a_i[0]),
    .fn         (fn),
    .spill      (spill_o)
  );

endmodule

// File: rtl/lsu_props.sv
module lsu_props #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] f_o,
  input logic             spill_o
);

  always_comb begin
    if (op_i == 3'b000) a_r1_and: assert (f_o == (a_i & b_i));
    if (op_i == 3'b001) a_r2_or: assert (f_o == (a_i | b_i));
    if (op_i == 3'b010) a_r3_inv: assert (f_o == ~a_i);
    if (op_i == 3'b011) a_r4_copy: assert (f_o == a_i);
    if (op_i == 3'b100) a_r5_shl: assert (f_o == (a_i << 1));
    if (op_i == 3'b101) a_r6_shr: assert (f_o == (a_i >> 1));
    if (op_i[2:1] == 2'b11) a_r7_rsv_zero: assert (f_o == '0 && !spill_o);
    if (op_i == 3'b100) a_r8_spill_hi: assert (spill_o == a_i[WIDTH-1]);
    if (op_i == 3'b101) a_r8_spill_lo: assert (spill_o == a_i[0]);
    if (op_i[2:1] != 2'b10) a_r8_spill_idle: assert (!spill_o);
  end

endmodule

bind bitslice_lsu lsu_props #(.WIDTH(WIDTH)) u_props (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .f_o     (f_o),
  .spill_o (spill_o)
);

// File: tb/tb_bitslice_lsu.sv
`timescale 1ns/1ps
module tb_bitslice_lsu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a_i = '0;
  logic [3:0] b_i = '0;
  logic [2:0] op_i = '0;
  logic [3:0] f_o;
  logic       spill_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitslice_lsu dut (
    .a_i     (a_i),
    .b_i     (b_i),
    .op_i    (op_i),
    .f_o     (f_o),
    .spill_o (spill_o)
  );

  // Behavioural reference using integer arithmetic.
  function automatic int ref_f(int op, int a, int b);
    case (op)
      0: return a & b;
      1: return a | b;
      2: return 15 - a;
      3: return a;
      4: return (a * 2) % 16;
      5: return a / 2;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_spill(int op, int a);
    if (op == 4) return (a >= 8) ? 1 : 0;
    if (op == 5) return a % 2;
    return 0;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(int op, int a, int b);
    int ef;
    int es;
    ef = ref_f(op, a, b);
    es = ref_spill(op, a);
    n_vec++;
    // R9: inputs applied this cycle, sampled before the next edge.
    if (int'(f_o) != ef) begin
      n_fail++;
      $display("FAIL %s R9 op=%0d a=%0d b=%0d: f_o=%0d expected %0d",
               tag_of(op), op, a, b, f_o, ef);
    end
    if (int'(spill_o) != es) begin
      n_fail++;
      $display("FAIL R8 op=%0d a=%0d: spill_o=%0d expected %0d",
               op, a, spill_o, es);
    end
  endtask

  initial begin
    // Reset-state check: all-zero inputs give a zero result.
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare(0, 0, 0);
    rst = 1'b0;

    // Exhaustive sweep, one vector per clock; b sweep covers R3/R4 b-independence.
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          #1;
          op_i = op[2:0];
          a_i  = a[3:0];
          b_i  = b[3:0];
          @(negedge clk);
          compare(op, a, b);
        end
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule